// File: doc/BRIEF.md
# Video Line Address Sequencer

This block produces the write addresses for a video frame buffer while a scaler streams pixels into it. It keeps a line address and a pixel address. From these it forms a linear memory address as line times pitch plus pixel. The pixel address advances once for every qualified pixel write.

A scaler marks line and field boundaries with an increment strobe and a half-full flag. The strobe comes from another timing domain, so the block synchronizes it into the pixel clock before use. It samples the flag level at the point where the strobe rise is first seen. A high flag means "next line": the line address advances and the pixel address clears. A low flag means "end of field or frame": both addresses return to zero.

For interlaced storage the scaler sends two strobe sequences per qualified line, so each field's lines land two lines apart. It also sends one extra sequence just after the field reset that opens an odd field, which moves that field down by one line. An interlace enable tells the block to keep a field-parity indication, and a pitch input sets the line stride in memory.

Top module: `vid_line_addr_seq`

## Requirements
- R1: While `rst` is high, and at the first clock after it, `line_addr`, `pix_addr` and `field_odd` are all 0.
- R2: A rising edge on `incr_strobe` with `half_flag` = 1 adds one to `line_addr` and sets `pix_addr` to 0. The change is visible after the third rising clock edge that samples the strobe high, counting the first such edge as edge one.
- R3: A rising edge on `incr_strobe` with `half_flag` = 0 sets both `line_addr` and `pix_addr` to 0, with the same timing as R2.
- R4: The flag level that decides between R2 and R3 is the one sampled at the same clock edge that first samples the strobe high. Flag changes after that edge have no effect on the action.
- R5: Each strobe rising edge causes exactly one action, however long the strobe then stays high.
- R6: On each clock edge with `pix_we` = 1 and no strobe action, `pix_addr` increments by one, modulo 2^PIX_W.
- R7: A line step taken from `line_addr` = NUM_LINES-1 sets `line_addr` to 0.
- R8: On a field reset, `field_odd` toggles when `interlace_en` = 1 and clears to 0 when `interlace_en` = 0. Line steps leave it unchanged.
- R9: With interlace enabled, doubled step sequences per line together with one extra step after the odd-field reset place the odd field on lines 1, 3, 5, … and the even field on lines 0, 2, 4, ….
- R10: Without a strobe edge, `line_addr` and `field_odd` hold indefinitely. There is no timeout, however long the gap.
- R11: `mem_addr` equals `line_addr * line_pitch + pix_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| incr_strobe | input | 1 | Asynchronous increment strobe from the scaler |
| half_flag | input | 1 | Line (1) or field (0) qualifier, sampled with the strobe |
| pix_we | input | 1 | Qualified pixel write enable |
| interlace_en | input | 1 | Interlaced storage enable |
| line_pitch | input | PITCH_W | Memory words per line |
| line_addr | output | LINE_W | Current line address |
| pix_addr | output | PIX_W | Current pixel address within the line |
| field_odd | output | 1 | Field parity indication |
| mem_addr | output | LINE_W+PITCH_W+1 | Linear write address |

## Verification
The bench builds the block with NUM_LINES = 8, PIX_W = 4 and PITCH_W = 6, and drives a pitch of 40. With eight lines, the wrap from line 7 back to line 0 is only eight steps away. With a four-bit pixel address, a burst of 18 writes carries the pixel counter through its modulo wrap. A vector table walks one progressive field and then two full interlaced fields, one odd and one even, checking the stride-two line placement. Directed tests then cover flag changes just after the sampling edge, a long-held strobe, a long idle gap and a mid-run reset.

// File: rtl/vlas_pkg.sv
package vlas_pkg;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_FIELD = 2'd2
    } act_e;

    typedef struct packed {
        logic strobe;
        logic flag;
    } strobe_smp_t;

    function automatic act_e decode_action(input logic rise, input logic flag);
        if (!rise)
            return ACT_NONE;
        return flag ? ACT_STEP : ACT_FIELD;
    endfunction

endpackage

// File: rtl/vlas_strobe_sync.sv
module vlas_strobe_sync
    import vlas_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    input  logic flag_in,
    output act_e act_o
);
    localparam int LAST = SYNC_STAGES - 1;

    strobe_smp_t stg [SYNC_STAGES];
    logic        strobe_prev;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= '{strobe: strobe_in, flag: flag_in};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= '0;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) strobe_prev <= 1'b0;
        else     strobe_prev <= stg[LAST].strobe;
    end

    always_comb begin
        act_o = decode_action(stg[LAST].strobe & ~strobe_prev, stg[LAST].flag);
    end

    // One action per strobe edge: an action is never followed by another
    assert_one_action_R5: assert property (@(posedge clk) disable iff (rst)
        (act_o != ACT_NONE) |=> (act_o == ACT_NONE));

endmodule

// File: rtl/vlas_line_ctr.sv
module vlas_line_ctr
    import vlas_pkg::*;
#(
    parameter int NUM_LINES = 576,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  act_e              act_i,
    input  logic              interlace_en,
    output logic [LINE_W-1:0] line_o,
    output logic              field_odd_o
);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(NUM_LINES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_o      <= '0;
            field_odd_o <= 1'b0;
        end else begin
            unique case (act_i)
                ACT_STEP: begin
                    line_o <= (line_o == LINE_LAST) ? '0 : line_o + 1'b1;
                end
                ACT_FIELD: begin
                    line_o      <= '0;
                    field_odd_o <= interlace_en ? ~field_odd_o : 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_field_reset_R3: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_FIELD) |=> (line_o == '0));

    assert_line_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_STEP && line_o == LINE_LAST) |=> (line_o == '0));

    assert_prog_parity_R8: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_FIELD && !interlace_en) |=> !field_odd_o);

    assert_step_keeps_parity_R8: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_STEP) |=> $stable(field_odd_o));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_NONE) |=> ($stable(line_o) && $stable(field_odd_o)));

endmodule

// File: rtl/vlas_pix_ctr.sv
module vlas_pix_ctr
    import vlas_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  act_e             act_i,
    input  logic             pix_we,
    output logic [PIX_W-1:0] pix_o
);
    always_ff @(posedge clk) begin
        if (rst)                     pix_o <= '0;
        else if (act_i != ACT_NONE)  pix_o <= '0;
        else if (pix_we)             pix_o <= pix_o + 1'b1;
    end

    assert_pix_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (act_i != ACT_NONE) |=> (pix_o == '0));

    assert_pix_count_R6: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_NONE && pix_we) |=> (pix_o == PIX_W'($past(pix_o) + 1'b1)));

endmodule

// File: rtl/vlas_addr_map.sv
module vlas_addr_map #(
    parameter int LINE_W  = 10,
    parameter int PIX_W   = 10,
    parameter int PITCH_W = 11,
    parameter int ADDR_W  = LINE_W + PITCH_W + 1
) (
    input  logic [LINE_W-1:0]  line_i,
    input  logic [PIX_W-1:0]   pix_i,
    input  logic [PITCH_W-1:0] pitch_i,
    output logic [ADDR_W-1:0]  addr_o
);
    always_comb begin
        addr_o = ADDR_W'(line_i) * ADDR_W'(pitch_i) + ADDR_W'(pix_i);
    end
endmodule

// File: rtl/vid_line_addr_seq.sv
module vid_line_addr_seq
    import vlas_pkg::*;
#(
    parameter int NUM_LINES   = 576,
    parameter int PIX_W       = 10,
    parameter int PITCH_W     = 11,
    parameter int SYNC_STAGES = 2,
    parameter int LINE_W      = $clog2(NUM_LINES),
    parameter int ADDR_W      = LINE_W + PITCH_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               incr_strobe,
    input  logic               half_flag,
    input  logic               pix_we,
    input  logic               interlace_en,
    input  logic [PITCH_W-1:0] line_pitch,
    output logic [LINE_W-1:0]  line_addr,
    output logic [PIX_W-1:0]   pix_addr,
    output logic               field_odd,
    output logic [ADDR_W-1:0]  mem_addr
);
    act_e act;

    vlas_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (incr_strobe),
        .flag_in   (half_flag),
        .act_o     (act)
    );

    vlas_line_ctr #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_line (
        .clk          (clk),
        .rst          (rst),
        .act_i        (act),
        .interlace_en (interlace_en),
        .line_o       (line_addr),
        .field_odd_o  (field_odd)
    );

    vlas_pix_ctr #(.PIX_W(PIX_W)) u_pix (
        .clk    (clk),
        .rst    (rst),
        .act_i  (act),
        .pix_we (pix_we),
        .pix_o  (pix_addr)
    );

    vlas_addr_map #(
        .LINE_W(LINE_W), .PIX_W(PIX_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)
    ) u_map (
        .line_i  (line_addr),
        .pix_i   (pix_addr),
        .pitch_i (line_pitch),
        .addr_o  (mem_addr)
    );

    // The first clock after reset always shows the cleared state
    assert_reset_state_R1: assert property (@(posedge clk)
        $fell(rst) |-> (line_addr == '0 && pix_addr == '0 && !field_odd));

endmodule

// File: tb/vid_line_addr_seq_bench.sv
module vid_line_addr_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NLINES     = 8;
    localparam int PW         = 4;
    localparam int PTW        = 6;
    localparam int LW         = 3;
    localparam int AW         = LW + PTW + 1;
    localparam int PITCH      = 40;

    // {interlace, flag, pixel writes[3:0], expected line[2:0], expected parity}
    localparam logic [9:0] VEC [16] = '{
        {1'b0, 1'b1, 4'd3, 3'd1, 1'b0},
        {1'b0, 1'b1, 4'd5, 3'd2, 1'b0},
        {1'b0, 1'b1, 4'd0, 3'd3, 1'b0},
        {1'b0, 1'b0, 4'd2, 3'd0, 1'b0},
        {1'b1, 1'b0, 4'd1, 3'd0, 1'b1},
        {1'b1, 1'b1, 4'd0, 3'd1, 1'b1},
        {1'b1, 1'b1, 4'd4, 3'd2, 1'b1},
        {1'b1, 1'b1, 4'd0, 3'd3, 1'b1},
        {1'b1, 1'b1, 4'd4, 3'd4, 1'b1},
        {1'b1, 1'b1, 4'd0, 3'd5, 1'b1},
        {1'b1, 1'b0, 4'd2, 3'd0, 1'b0},
        {1'b1, 1'b1, 4'd3, 3'd1, 1'b0},
        {1'b1, 1'b1, 4'd0, 3'd2, 1'b0},
        {1'b1, 1'b1, 4'd3, 3'd3, 1'b0},
        {1'b1, 1'b0, 4'd0, 3'd0, 1'b1},
        {1'b1, 1'b1, 4'd0, 3'd1, 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           incr_strobe = 1'b0;
    logic           half_flag = 1'b0;
    logic           pix_we = 1'b0;
    logic           interlace_en = 1'b0;
    logic [PTW-1:0] line_pitch = PTW'(PITCH);
    logic [LW-1:0]  line_addr;
    logic [PW-1:0]  pix_addr;
    logic           field_odd;
    logic [AW-1:0]  mem_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_line_addr_seq #(
        .NUM_LINES(NLINES), .PIX_W(PW), .PITCH_W(PTW)
    ) u_vid_line_addr_seq (
        .clk(clk), .rst(rst), .incr_strobe(incr_strobe), .half_flag(half_flag),
        .pix_we(pix_we), .interlace_en(interlace_en), .line_pitch(line_pitch),
        .line_addr(line_addr), .pix_addr(pix_addr), .field_odd(field_odd),
        .mem_addr(mem_addr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_pixels(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pix_we = 1'b1;
        end
        @(negedge clk) pix_we = 1'b0;
    endtask

    // Rise the strobe with a flag; sample after the third sampling edge
    task automatic strobe(input logic f, input int hold);
        @(negedge clk);
        incr_strobe = 1'b1;
        half_flag   = f;
        for (int i = 0; i < hold; i++) @(negedge clk);
    endtask

    task automatic strobe_release();
        incr_strobe = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R10 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int exp_line;
        int exp_pix;
        repeat (4) @(negedge clk);
        chk("R1", "line in reset", int'(line_addr), 0);
        chk("R1", "pixel in reset", int'(pix_addr), 0);
        chk("R1", "parity in reset", int'(field_odd), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "line after reset", int'(line_addr), 0);

        // Vector walk: progressive field, then odd and even interlaced fields (R9)
        for (int v = 0; v < 16; v++) begin
            interlace_en = VEC[v][9];
            write_pixels(int'(VEC[v][7:4]));
            chk("R6", "pixel count", int'(pix_addr), int'(VEC[v][7:4]));
            chk("R11", "memory address", int'(mem_addr),
                int'(line_addr) * PITCH + int'(VEC[v][7:4]));
            strobe(VEC[v][8], 3);
            chk(VEC[v][8] ? "R2 R9" : "R3 R9", "line", int'(line_addr), int'(VEC[v][3:1]));
            chk("R2", "pixel after action", int'(pix_addr), 0);
            chk("R8", "parity", int'(field_odd), int'(VEC[v][0]));
            strobe_release();
        end

        // R8 progressive field reset clears parity (currently 1); R7 wrap
        interlace_en = 1'b0;
        strobe(1'b0, 3);
        chk("R8", "parity cleared", int'(field_odd), 0);
        chk("R3", "line reset", int'(line_addr), 0);
        strobe_release();
        exp_line = 0;
        for (int i = 0; i < NLINES - 1; i++) begin
            strobe(1'b1, 3);
            strobe_release();
            exp_line++;
        end
        chk("R7", "last line", int'(line_addr), exp_line);
        strobe(1'b1, 3);
        chk("R7", "wrapped line", int'(line_addr), 0);
        strobe_release();

        // R4: flag drops right after the sampling edge, still a step
        strobe(1'b1, 1);
        half_flag = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R4", "late flag fall ignored", int'(line_addr), 1);
        strobe_release();
        write_pixels(3);
        // R4: flag rises right after the sampling edge, still a field reset
        strobe(1'b0, 1);
        half_flag = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R4", "late flag rise ignored", int'(line_addr), 0);
        chk("R3", "pixel cleared on field", int'(pix_addr), 0);
        strobe_release();

        // R5: strobe held high for many cycles gives one step
        strobe(1'b1, 12);
        chk("R5", "one step for long strobe", int'(line_addr), 1);
        strobe_release();

        // R10: long idle gap, no timeout
        write_pixels(5);
        repeat (100) @(negedge clk);
        chk("R10", "line after idle", int'(line_addr), 1);
        chk("R10", "pixel after idle", int'(pix_addr), 5);

        // R6: pixel wrap modulo 16
        write_pixels(18);
        exp_pix = (5 + 18) % 16;
        chk("R6", "pixel wrap", int'(pix_addr), exp_pix);
        chk("R11", "memory address after wrap", int'(mem_addr), 1 * PITCH + exp_pix);

        // R1: mid-run reset
        interlace_en = 1'b1;
        strobe(1'b0, 3);
        strobe_release();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "line after mid reset", int'(line_addr), 0);
        chk("R1", "parity after mid reset", int'(field_odd), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule